// File: doc/BRIEF.md
# Program Memory Word Reader

This peripheral gives software read access to an on-chip program memory through five byte-wide registers. Software loads a word address, high byte and low byte, into two address registers. It then sets a start bit in a control register. The block latches the address and drives a one-cycle request on a simple synchronous memory read port. One clock later it captures the returned word into two data registers, which hold the low byte and the upper bits. The start bit clears by itself in the cycle the data lands, so software can poll that bit to learn when the result is ready.

The start bit is set-only from the register side; only the sequencer clears it. Bits that have no storage behind them return fixed constants. Because the address is latched when a read begins, software may load the next address while a read is still in flight. A start written in the cycle a read completes chains straight into a new read.

Top module: `pm_reader`

## Requirements
- R1: After reset the control register reads 80h, and the address and data registers read 00h.
- R2: In the control register, bit 7 always reads 1, bits 6 to 1 always read 0, and bit 0 reads the start/busy bit.
- R3: A register write with bit 0 set to the control register starts a read when no read is in its memory access cycle. A write with bit 0 clear never starts or stops a read. A start written during the memory access cycle is ignored.
- R4: The cycle after the starting write, mem_en_o is high for exactly one cycle and mem_addr_o shows the latched address. The start bit clears, and the data registers update, at the second clock edge after the starting write.
- R5: The data word is 14 bits wide. The data-low register (10Dh) holds word bits 7:0. The data-high register (10Eh) holds word bits 13:8 in its bits 5:0, and its bits 7:6 read 0.
- R6: The word address is 13 bits wide. The address-low register (10Fh) holds address bits 7:0. The address-high register (110h) holds address bits 12:8 in its bits 4:0. Bits 7:5 written to the address-high register are discarded and read back as 0.
- R7: Writes to the address registers during a read are accepted and read back at once. The read in flight uses the address latched at its start, and the new address serves the next read.
- R8: Register writes to the data-low and data-high registers leave their contents unchanged.
- R9: A start written in the completion cycle of a read begins a new read at once. The start bit stays 1, the completing read's word is captured, and the new read delivers its own word two edges later.
- R10: The control register sits at register address 10Ch. Reads of register addresses other than 10Ch to 110h return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register byte address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| mem_en_o | output | 1 | Program memory read request |
| mem_addr_o | output | 13 | Program memory word address |
| mem_data_i | input | 14 | Program memory data, valid the cycle after mem_en_o |

## Verification
Two things can share a clock edge. The first is a read's completion, where the data is captured and the start bit clears. The second is a fresh start write, or an address write into the same read. The bench provokes both pairs. It loads a new address during the memory access cycle, then writes the start bit exactly on the completion edge. It then checks that the start bit never drops and that the request carries the new address. It also checks that the data registers first show the word of the old address and, two edges later, the word of the new one.

// File: rtl/pm_reader_pkg.sv
package pm_reader_pkg;
  localparam int unsigned PMR_ADDR_W = 13;
  localparam int unsigned PMR_DATA_W = 14;
  localparam int unsigned PMR_RA_W   = 9;
  localparam logic [8:0]  PMR_CTRL   = 9'h10C;

  typedef enum logic [1:0] {
    RD_IDLE    = 2'd0,
    RD_ACCESS  = 2'd1,
    RD_CAPTURE = 2'd2
  } rd_state_e;
endpackage

// File: rtl/pm_read_seq.sv
module pm_read_seq
  import pm_reader_pkg::*;
#(
  parameter int unsigned ADDR_W = PMR_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] lat_q;
  logic              accept;

  // start is refused only while the memory request is on the port
  assign accept = start_i && (state_q != RD_ACCESS);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RD_IDLE:    if (accept) state_d = RD_ACCESS;
      RD_ACCESS:  state_d = RD_CAPTURE;
      RD_CAPTURE: state_d = accept ? RD_ACCESS : RD_IDLE;
      default:    state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) lat_q <= word_addr_i;
    end
  end

  assign busy_o     = (state_q != RD_IDLE);
  assign done_o     = (state_q == RD_CAPTURE);
  assign mem_en_o   = (state_q == RD_ACCESS);
  assign mem_addr_o = lat_q;
endmodule

// File: rtl/pm_regfile.sv
module pm_regfile
  import pm_reader_pkg::*;
#(
  parameter int unsigned ADDR_W = PMR_ADDR_W,
  parameter int unsigned DATA_W = PMR_DATA_W,
  parameter int unsigned RA_W   = PMR_RA_W,
  parameter logic [RA_W-1:0] CTRL_ADDR = PMR_CTRL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RA_W-1:0]   addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              busy_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [DATA_W-1:0] data_word_o
);
  localparam int unsigned AHI_W = ADDR_W - 8;
  localparam int unsigned DHI_W = DATA_W - 8;
  localparam logic [RA_W-1:0] DLO_ADDR = CTRL_ADDR + RA_W'(1);
  localparam logic [RA_W-1:0] DHI_ADDR = CTRL_ADDR + RA_W'(2);
  localparam logic [RA_W-1:0] ALO_ADDR = CTRL_ADDR + RA_W'(3);
  localparam logic [RA_W-1:0] AHI_ADDR = CTRL_ADDR + RA_W'(4);

  logic [7:0]        alo_q;
  logic [AHI_W-1:0]  ahi_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alo_q  <= '0;
      ahi_q  <= '0;
      data_q <= '0;
    end else begin
      if (we_i && addr_i == ALO_ADDR) alo_q <= wdata_i;
      if (we_i && addr_i == AHI_ADDR) ahi_q <= wdata_i[AHI_W-1:0];
      if (cap_i) data_q <= cap_data_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      CTRL_ADDR: rdata_o = {1'b1, 6'b0, busy_i};
      DLO_ADDR:  rdata_o = data_q[7:0];
      DHI_ADDR:  rdata_o = 8'(data_q[DATA_W-1:8]);
      ALO_ADDR:  rdata_o = alo_q;
      AHI_ADDR:  rdata_o = 8'(ahi_q);
      default:   rdata_o = 8'h00;
    endcase
  end

  assign word_addr_o = {ahi_q, alo_q};
  assign data_word_o = data_q;

  if (DHI_W > 8 || AHI_W > 8) begin : g_bad_width
    initial $error("pm_regfile: high part wider than a byte");
  end
endmodule

// File: rtl/pm_reader.sv
module pm_reader
  import pm_reader_pkg::*;
#(
  parameter int unsigned ADDR_W = PMR_ADDR_W,
  parameter int unsigned DATA_W = PMR_DATA_W,
  parameter int unsigned RA_W   = PMR_RA_W,
  parameter logic [RA_W-1:0] CTRL_ADDR = PMR_CTRL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i
);
  logic              start_wr;
  logic              rd_busy;
  logic              rd_done;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] data_word;

  // only a 1 in bit 0 requests a read; a 0 cannot clear the start bit
  assign start_wr = reg_we_i && (reg_addr_i == CTRL_ADDR) && reg_wdata_i[0];

  pm_read_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_wr),
    .word_addr_i (word_addr),
    .busy_o      (rd_busy),
    .done_o      (rd_done),
    .mem_en_o    (mem_en_o),
    .mem_addr_o  (mem_addr_o)
  );

  pm_regfile #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RA_W      (RA_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (rd_busy),
    .cap_i       (rd_done),
    .cap_data_i  (mem_data_i),
    .rdata_o     (reg_rdata_o),
    .word_addr_o (word_addr),
    .data_word_o (data_word)
  );
endmodule

// File: rtl/pm_reader_chk.sv
module pm_reader_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 14,
  parameter int unsigned RA_W   = 9,
  parameter logic [RA_W-1:0] CTRL_ADDR = 9'h10C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [RA_W-1:0]   reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic              mem_en_o,
  input logic [DATA_W-1:0] mem_data_i,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] data_word
);
  localparam logic [RA_W-1:0] DHI_ADDR = CTRL_ADDR + RA_W'(2);
  localparam logic [RA_W-1:0] AHI_ADDR = CTRL_ADDR + RA_W'(4);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == CTRL_ADDR);

  // R2
  ctrl_const_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == CTRL_ADDR) |-> (reg_rdata_o[7:1] == 7'h40 && reg_rdata_o[0] == busy));

  // R3
  no_sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done && ctrl_wr && !reg_wdata_i[0]) |=> busy);

  // R4
  single_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |=> (!mem_en_o && busy));

  // R4
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !(ctrl_wr && reg_wdata_i[0])) |=> !busy);

  // R5
  data_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done) |-> (data_word == $past(mem_data_i)));

  // R5
  data_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == DHI_ADDR) |-> ((reg_rdata_o >> (DATA_W - 8)) == 8'h00));

  // R6
  addr_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AHI_ADDR) |-> ((reg_rdata_o >> (ADDR_W - 8)) == 8'h00));
endmodule

bind pm_reader pm_reader_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .RA_W      (RA_W),
  .CTRL_ADDR (CTRL_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mem_en_o    (mem_en_o),
  .mem_data_i  (mem_data_i),
  .busy        (rd_busy),
  .done        (rd_done),
  .data_word   (data_word)
);

// File: tb/pm_reader_test.sv
module pm_reader_test;
  localparam logic [8:0] A_CTRL = 9'h10C;
  localparam logic [8:0] A_DLO  = 9'h10D;
  localparam logic [8:0] A_DHI  = 9'h10E;
  localparam logic [8:0] A_ALO  = 9'h10F;
  localparam logic [8:0] A_AHI  = 9'h110;

  // {hi byte written, lo byte written, expected 13-bit word address}
  localparam logic [31:0] VEC [8] = '{
    32'h0000_0000, 32'h0001_0001, 32'h00FF_00FF, 32'h0100_0100,
    32'hFABC_1ABC, 32'h1FFF_1FFF, 32'hEA5A_0A5A, 32'h1555_1555
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [8:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        mem_en_o;
  logic [12:0] mem_addr_o;
  logic [13:0] mem_q = '0;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  pm_reader uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .mem_en_o    (mem_en_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_i  (mem_q)
  );

  function automatic logic [13:0] pm_word(input logic [12:0] a);
    logic [13:0] t;
    t = 14'(32'(a) * 7 + 3);
    return t ^ {a[12:6], 7'h0} ^ 14'h2C35;
  endfunction

  always_ff @(posedge clk_i) if (mem_en_o) mem_q <= pm_word(mem_addr_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    #1 reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] v);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic set_addr(input logic [12:0] a);
    wr(A_ALO, a[7:0]);
    wr(A_AHI, {3'b0, a[12:8]});
  endtask

  task automatic chk_data(input string req, input logic [13:0] w);
    logic [7:0] v;
    rd(A_DLO, v); chk(req, v, w[7:0]);
    rd(A_DHI, v); chk(req, v, {2'b0, w[13:8]});
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [12:0] a;
    repeat (3) @(negedge clk_i);
    // R1 during and after reset
    rd(A_CTRL, v); chk("R1", v, 8'h80);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(A_CTRL, v); chk("R1", v, 8'h80);
    rd(A_DLO, v);  chk("R1", v, 8'h00);
    rd(A_DHI, v);  chk("R1", v, 8'h00);
    rd(A_ALO, v);  chk("R1", v, 8'h00);
    rd(A_AHI, v);  chk("R1", v, 8'h00);
    chk("R1", mem_en_o, 1'b0);
    // R10 unmapped addresses
    rd(9'h10B, v); chk("R10", v, 8'h00);
    rd(9'h111, v); chk("R10", v, 8'h00);
    rd(9'h00C, v); chk("R10", v, 8'h00);

    // vector walk: R4 R5 R6
    foreach (VEC[i]) begin
      a = VEC[i][12:0];
      wr(A_ALO, VEC[i][23:16]);
      wr(A_AHI, VEC[i][31:24]);
      rd(A_ALO, v); chk("R6", v, a[7:0]);
      rd(A_AHI, v); chk("R6", v, {3'b0, a[12:8]});
      wr(A_CTRL, 8'h01);
      @(negedge clk_i);
      chk("R4", mem_en_o, 1'b1);
      chk("R4", mem_addr_o, a);
      rd(A_CTRL, v); chk("R2", v, 8'h81);
      @(negedge clk_i);
      chk("R4", mem_en_o, 1'b0);
      rd(A_CTRL, v); chk("R4", v, 8'h81);
      @(negedge clk_i);
      rd(A_CTRL, v); chk("R4", v, 8'h80);
      chk_data("R5", pm_word(a));
    end

    // R3 write 0 while idle does nothing
    wr(A_CTRL, 8'hFE);
    @(negedge clk_i);
    chk("R3", mem_en_o, 1'b0);
    rd(A_CTRL, v); chk("R3", v, 8'h80);

    // R3 write 0 while busy does not clear
    set_addr(13'h0123);
    wr(A_CTRL, 8'h01);
    wr(A_CTRL, 8'h00);
    @(negedge clk_i);
    rd(A_CTRL, v); chk("R3", v, 8'h81);
    @(negedge clk_i);
    rd(A_CTRL, v); chk("R3", v, 8'h80);
    chk_data("R3", pm_word(13'h0123));

    // R3 start during access cycle ignored
    wr(A_CTRL, 8'h01);
    wr(A_CTRL, 8'h01);
    @(negedge clk_i);
    chk("R3", mem_en_o, 1'b0);
    @(negedge clk_i);
    rd(A_CTRL, v); chk("R3", v, 8'h80);

    // R8 data register writes ignored
    wr(A_DLO, 8'hFF);
    wr(A_DHI, 8'hFF);
    @(negedge clk_i);
    chk_data("R8", pm_word(13'h0123));

    // R7 address write during a read
    set_addr(13'h0456);
    wr(A_CTRL, 8'h01);
    wr(A_ALO, 8'h99);
    @(negedge clk_i);
    rd(A_ALO, v); chk("R7", v, 8'h99);
    @(negedge clk_i);
    rd(A_CTRL, v); chk("R7", v, 8'h80);
    chk_data("R7", pm_word(13'h0456));
    wr(A_CTRL, 8'h01);
    @(negedge clk_i);
    chk("R7", mem_addr_o, 13'h0499);
    @(negedge clk_i);
    @(negedge clk_i);
    chk_data("R7", pm_word(13'h0499));

    // R9 start in completion cycle, with address changed mid-read
    set_addr(13'h1A01);
    wr(A_CTRL, 8'h01);
    wr(A_ALO, 8'h77);
    wr(A_CTRL, 8'h01);
    @(negedge clk_i);
    rd(A_CTRL, v); chk("R9", v, 8'h81);
    chk("R9", mem_en_o, 1'b1);
    chk("R9", mem_addr_o, 13'h1A77);
    chk_data("R9", pm_word(13'h1A01));
    @(negedge clk_i);
    rd(A_CTRL, v); chk("R9", v, 8'h81);
    @(negedge clk_i);
    rd(A_CTRL, v); chk("R9", v, 8'h80);
    chk_data("R9", pm_word(13'h1A77));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule